// File: doc/BRIEF.md
# Host Memory Access Port

This block lets an external host read and write the on-chip program and data memories over a 16-bit bus that carries both addresses and data. The host works without any clock of its own. It asserts a select line and pulses an address-latch strobe. When that strobe falls, the port captures one of two things from the bus: a start address with a program/data memory flag, or an overlay page selection. The host then runs reads and writes with active-low read and write strobes. After each word the port steps the internal address, so a block transfer needs only its first address.

All host strobes cross into the core clock through two-flop synchronizers. Each word costs the memory exactly one core cycle. Program words are 24 bits wide and travel as two bus accesses. The first access carries the upper 16 bits. The second carries the low 8 bits, right-justified. The address steps only after the second access.

An acknowledge output is high while the port is idle. It drops while an accepted access is in progress and rises again when that access is complete. A read result is valid on the output bus once the acknowledge has risen.

Top module: `host_mem_port`

## Requirements
- R1: After reset, hostAck is 1, memReq is 0, ovlSel is 0 and hostBusOut is 0. The internal address is data memory word 0, with the program-word phase at its first half.
- R2: A latch word with bit 15 = 0 loads the address from bits 13:0. Bit 14 selects the memory: 1 for program memory, 0 for data memory. The program-word phase returns to its first half.
- R3: A latch word with bit 15 = 1 and bits 14:8 all zero loads ovlSel from bits 7:0. The address and the phase do not change.
- R4: A latch word with bit 15 = 1 and any of bits 14:8 set is ignored. ovlSel, the address and the phase stay as they were.
- R5: A data memory read issues one memory cycle with memWe = 0. When hostAck rises, hostBusOut equals memRdata[15:0]. memRdata is returned in the cycle after memReq.
- R6: A data memory write issues one memory cycle with memWe = 1 and memWdata = {8'h00, bus word}.
- R7: The address steps by one after each data memory word, and wraps from 14'h3FFF to 0.
- R8: A program memory read fetches the word once, on the first access, and presents memRdata[23:8]. The second access presents {8'h00, memRdata[7:0]} without a memory cycle. The address steps after the second access.
- R9: The first access of a program memory write stores its bus word and makes no memory cycle. The second access writes {stored word, bus[7:0]} in one memory cycle. The address steps after that write.
- R10: A data memory write at an address at or above CTRL_BASE (default 14'h3FE0) makes no memory cycle, but the address still steps.
- R11: hostAck is low while an accepted access is in progress. Every memory cycle lasts exactly one clock, and memWe is never high without memReq.
- R12: A host strobe takes at least two core clock edges to take effect. hostAck stays high and memReq low for the first two edges after a strobe is asserted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Active-low reset |
| hostSelN | input | 1 | Host port select, active low |
| hostLatch | input | 1 | Address latch strobe; the bus is captured on its falling edge |
| hostRdN | input | 1 | Host read strobe, active low |
| hostWrN | input | 1 | Host write strobe, active low |
| hostBusIn | input | 16 | Bus word driven by the host |
| hostBusOut | output | 16 | Read data presented to the host |
| hostBusOe | output | 1 | Output enable for hostBusOut while the host reads |
| hostAck | output | 1 | High when idle; low while an access is in progress |
| memReq | output | 1 | One-cycle memory access request |
| memWe | output | 1 | Write qualifier for memReq |
| memIsPm | output | 1 | 1 selects program memory, 0 data memory |
| memAddr | output | 14 | Memory word address |
| memWdata | output | 24 | Write data |
| memRdata | input | 24 | Read data, valid the cycle after memReq |
| ovlSel | output | 8 | Overlay page selection |

## Verification
The bench targets the split of program words.

- **Program words.** A design that stepped the address after the first half, or fetched memory twice, would return the wrong low byte. It would also show an extra memory request.
- **Latch decoding.** Overlay words with nonzero reserved bits are sent to the port. A port that accepted them would change ovlSel. A port that treated an overlay word as an address would move the next read.
- **Protected region.** A write at the top of data memory must issue no memory cycle and must still advance the address. The wrap from 14'h3FFF to 0 is confirmed by the following read.
- **Synchronizer delay.** Early sampling checks that acknowledge does not drop before the strobe has passed both synchronizer flops.

// File: rtl/hmp_pkg.sv
package hmp_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_MEMRD,
    ST_CAPT,
    ST_MEMWR,
    ST_FINRD,
    ST_FINWR
  } ctrlState_t;

  // strobes from control to datapath, one cycle each
  typedef struct packed {
    logic latchWord;  // decode the bus as a latch word
    logic reqRd;      // start a memory read cycle
    logic reqWr;      // start a memory write cycle
    logic dropReq;    // end the memory cycle
    logic capRd;      // capture returned read data
    logic outLow;     // present the held low byte of a program word
    logic holdHi;     // store the upper part of a program word
    logic step;       // word half finished: advance phase or address
    logic busySet;
    logic busyClr;
  } strobe_t;

endpackage

// File: rtl/hmp_sync.sv
module hmp_sync #(
  parameter int WIDTH = 4,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  generate
    for (genvar gi = 0; gi < WIDTH; gi++) begin : g_bit
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain <= {STAGES{RST_VAL[gi]}};
        else       chain <= {chain[STAGES-2:0], asyncIn[gi]};
      end
      assign syncOut[gi] = chain[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/hmp_ctrl.sv
module hmp_ctrl
  import hmp_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    selS,     // synchronized select, active low
  input  logic    latchS,   // synchronized latch strobe
  input  logic    rdS,      // synchronized read strobe, active low
  input  logic    wrS,      // synchronized write strobe, active low
  input  logic    isPm,
  input  logic    pmPhase,
  input  logic    protHit,
  output strobe_t strobe
);

  ctrlState_t state, nextState;
  logic latchPrev, rdActPrev, wrActPrev;
  logic rdAct, wrAct, latchEv, rdEv, wrEv;

  assign rdAct   = !selS && !rdS;
  assign wrAct   = !selS && !wrS && rdS;
  assign latchEv = latchPrev && !latchS && !selS;
  assign rdEv    = rdAct && !rdActPrev;
  assign wrEv    = wrAct && !wrActPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      latchPrev <= 1'b0;
      rdActPrev <= 1'b0;
      wrActPrev <= 1'b0;
    end else begin
      state     <= nextState;
      latchPrev <= latchS;
      rdActPrev <= rdAct;
      wrActPrev <= wrAct;
    end
  end

  always_comb begin
    strobe    = '0;
    nextState = state;
    case (state)
      ST_IDLE: begin
        if (latchEv) begin
          strobe.latchWord = 1'b1;
        end else if (rdEv) begin
          strobe.busySet = 1'b1;
          if (isPm && pmPhase) begin
            nextState = ST_FINRD;
          end else begin
            strobe.reqRd = 1'b1;
            nextState    = ST_MEMRD;
          end
        end else if (wrEv) begin
          strobe.busySet = 1'b1;
          if (isPm && !pmPhase) begin
            strobe.holdHi = 1'b1;
            nextState     = ST_FINWR;
          end else if (protHit) begin
            nextState = ST_FINWR;
          end else begin
            strobe.reqWr = 1'b1;
            nextState    = ST_MEMWR;
          end
        end
      end
      ST_MEMRD: begin
        strobe.dropReq = 1'b1;
        nextState      = ST_CAPT;
      end
      ST_CAPT: begin
        strobe.capRd   = 1'b1;
        strobe.step    = 1'b1;
        strobe.busyClr = 1'b1;
        nextState      = ST_IDLE;
      end
      ST_MEMWR: begin
        strobe.dropReq = 1'b1;
        strobe.step    = 1'b1;
        strobe.busyClr = 1'b1;
        nextState      = ST_IDLE;
      end
      ST_FINRD: begin
        strobe.outLow  = 1'b1;
        strobe.step    = 1'b1;
        strobe.busyClr = 1'b1;
        nextState      = ST_IDLE;
      end
      ST_FINWR: begin
        strobe.step    = 1'b1;
        strobe.busyClr = 1'b1;
        nextState      = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/hmp_datapath.sv
module hmp_datapath
  import hmp_pkg::*;
#(
  parameter int ADDR_W = 14,
  parameter int BUS_W = 16,
  parameter int PM_W = 24,
  parameter int OVL_W = 8,
  parameter int CTRL_BASE = 16'h3FE0
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobe,
  input  logic [BUS_W-1:0]  busIn,
  input  logic [PM_W-1:0]   memRdata,
  output logic [BUS_W-1:0]  busOut,
  output logic              ack,
  output logic              memReq,
  output logic              memWe,
  output logic              memIsPm,
  output logic [ADDR_W-1:0] memAddr,
  output logic [PM_W-1:0]   memWdata,
  output logic [OVL_W-1:0]  ovlSel,
  output logic              isPm,
  output logic              pmPhase,
  output logic              protHit
);

  localparam int LOW_W   = PM_W - BUS_W;
  localparam int OVL_BIT = BUS_W - 1;
  localparam int PM_BIT  = BUS_W - 2;
  localparam logic [ADDR_W-1:0] PROT_BASE = ADDR_W'(CTRL_BASE);

  logic [ADDR_W-1:0] addrQ;
  logic              isPmQ, phaseQ, busyQ, reqQ, weQ;
  logic [BUS_W-1:0]  hiHold, outQ;
  logic [LOW_W-1:0]  lowBuf;
  logic [PM_W-1:0]   wdataQ;
  logic [OVL_W-1:0]  ovlQ;
  logic              isOvlWord, resvClear;

  assign isOvlWord = busIn[OVL_BIT];
  assign resvClear = (busIn[PM_BIT:OVL_W] == '0);

  // address, memory select and word phase
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ  <= '0;
      isPmQ  <= 1'b0;
      phaseQ <= 1'b0;
      ovlQ   <= '0;
    end else if (strobe.latchWord) begin
      if (isOvlWord) begin
        if (resvClear) ovlQ <= busIn[OVL_W-1:0];
      end else begin
        addrQ  <= busIn[ADDR_W-1:0];
        isPmQ  <= busIn[PM_BIT];
        phaseQ <= 1'b0;
      end
    end else if (strobe.step) begin
      if (isPmQ && !phaseQ) begin
        phaseQ <= 1'b1;
      end else begin
        phaseQ <= 1'b0;
        addrQ  <= addrQ + 1'b1;
      end
    end
  end

  // memory cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqQ   <= 1'b0;
      weQ    <= 1'b0;
      wdataQ <= '0;
    end else if (strobe.reqRd) begin
      reqQ <= 1'b1;
      weQ  <= 1'b0;
    end else if (strobe.reqWr) begin
      reqQ   <= 1'b1;
      weQ    <= 1'b1;
      wdataQ <= isPmQ ? {hiHold, busIn[LOW_W-1:0]} : {{LOW_W{1'b0}}, busIn};
    end else if (strobe.dropReq) begin
      reqQ <= 1'b0;
      weQ  <= 1'b0;
    end
  end

  // host-side data and busy
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyQ  <= 1'b0;
      hiHold <= '0;
      outQ   <= '0;
      lowBuf <= '0;
    end else begin
      if (strobe.busySet)      busyQ <= 1'b1;
      else if (strobe.busyClr) busyQ <= 1'b0;
      if (strobe.holdHi) hiHold <= busIn;
      if (strobe.capRd) begin
        if (isPmQ) begin
          outQ   <= memRdata[PM_W-1:LOW_W];
          lowBuf <= memRdata[LOW_W-1:0];
        end else begin
          outQ <= memRdata[BUS_W-1:0];
        end
      end else if (strobe.outLow) begin
        outQ <= {{(BUS_W-LOW_W){1'b0}}, lowBuf};
      end
    end
  end

  assign busOut   = outQ;
  assign ack      = !busyQ;
  assign memReq   = reqQ;
  assign memWe    = weQ;
  assign memIsPm  = isPmQ;
  assign memAddr  = addrQ;
  assign memWdata = wdataQ;
  assign ovlSel   = ovlQ;
  assign isPm     = isPmQ;
  assign pmPhase  = phaseQ;
  assign protHit  = !isPmQ && (addrQ >= PROT_BASE);

endmodule

// File: rtl/host_mem_port.sv
module host_mem_port
  import hmp_pkg::*;
#(
  parameter int ADDR_W = 14,
  parameter int BUS_W = 16,
  parameter int PM_W = 24,
  parameter int OVL_W = 8,
  parameter int SYNC_STAGES = 2,
  parameter int CTRL_BASE = 16'h3FE0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostSelN,
  input  logic              hostLatch,
  input  logic              hostRdN,
  input  logic              hostWrN,
  input  logic [BUS_W-1:0]  hostBusIn,
  output logic [BUS_W-1:0]  hostBusOut,
  output logic              hostBusOe,
  output logic              hostAck,
  output logic              memReq,
  output logic              memWe,
  output logic              memIsPm,
  output logic [ADDR_W-1:0] memAddr,
  output logic [PM_W-1:0]   memWdata,
  input  logic [PM_W-1:0]   memRdata,
  output logic [OVL_W-1:0]  ovlSel
);

  localparam int NSYNC = 4;

  logic [NSYNC-1:0] rawStrobes, syncStrobes;
  strobe_t strobe;
  logic isPm, pmPhase, protHit;

  // order: select, latch, read, write
  assign rawStrobes = {hostSelN, hostLatch, hostRdN, hostWrN};

  hmp_sync #(
    .WIDTH(NSYNC), .STAGES(SYNC_STAGES), .RST_VAL(4'b1011)
  ) u_sync (
    .clk(clk), .rstN(rstN), .asyncIn(rawStrobes), .syncOut(syncStrobes)
  );

  hmp_ctrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .selS(syncStrobes[3]), .latchS(syncStrobes[2]),
    .rdS(syncStrobes[1]), .wrS(syncStrobes[0]),
    .isPm(isPm), .pmPhase(pmPhase), .protHit(protHit),
    .strobe(strobe)
  );

  hmp_datapath #(
    .ADDR_W(ADDR_W), .BUS_W(BUS_W), .PM_W(PM_W), .OVL_W(OVL_W),
    .CTRL_BASE(CTRL_BASE)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .busIn(hostBusIn),
    .memRdata(memRdata), .busOut(hostBusOut), .ack(hostAck),
    .memReq(memReq), .memWe(memWe), .memIsPm(memIsPm), .memAddr(memAddr),
    .memWdata(memWdata), .ovlSel(ovlSel), .isPm(isPm), .pmPhase(pmPhase),
    .protHit(protHit)
  );

  assign hostBusOe = !hostSelN && !hostRdN;

endmodule

// File: rtl/hmp_checker.sv
module hmp_checker #(
  parameter int ADDR_W = 14,
  parameter int OVL_W = 8,
  parameter int CTRL_BASE = 16'h3FE0
) (
  input logic              clk,
  input logic              rstN,
  input logic              hostAck,
  input logic              memReq,
  input logic              memWe,
  input logic              memIsPm,
  input logic [ADDR_W-1:0] memAddr,
  input logic [OVL_W-1:0]  ovlSel
);

  localparam logic [ADDR_W-1:0] PROT_BASE = ADDR_W'(CTRL_BASE);

  // R11
  single_steal_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq |=> !memReq);

  // R11
  req_while_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> !hostAck);

  // R6
  we_with_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> memReq);

  // R10
  no_ctrl_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memWe && !memIsPm) |-> (memAddr < PROT_BASE));

  // R3
  ovl_steady_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!hostAck && $past(!hostAck)) |-> $stable(ovlSel));

endmodule

bind host_mem_port hmp_checker #(
  .ADDR_W(ADDR_W), .OVL_W(OVL_W), .CTRL_BASE(CTRL_BASE)
) u_chk (
  .clk(clk), .rstN(rstN), .hostAck(hostAck), .memReq(memReq),
  .memWe(memWe), .memIsPm(memIsPm), .memAddr(memAddr), .ovlSel(ovlSel)
);

// File: tb/host_mem_port_bench.sv
`timescale 1ns/1ps
module host_mem_port_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hostSelN = 1'b1, hostLatch = 1'b0, hostRdN = 1'b1, hostWrN = 1'b1;
  logic [15:0] hostBusIn = '0;
  logic [15:0] hostBusOut;
  logic        hostBusOe, hostAck, memReq, memWe, memIsPm;
  logic [13:0] memAddr;
  logic [23:0] memWdata;
  logic [23:0] memRdata = '0;
  logic [7:0]  ovlSel;

  int checks = 0, fails = 0;
  int reqCount = 0, wrCount = 0;
  logic [13:0] lastWrAddr = '0;
  logic [23:0] lastWrData = '0;
  logic        lastWrPm = 1'b0;
  logic        finished = 1'b0;

  always #10 clk = ~clk;

  host_mem_port u_host_mem_port (
    .clk(clk), .rstN(rstN), .hostSelN(hostSelN), .hostLatch(hostLatch),
    .hostRdN(hostRdN), .hostWrN(hostWrN), .hostBusIn(hostBusIn),
    .hostBusOut(hostBusOut), .hostBusOe(hostBusOe), .hostAck(hostAck),
    .memReq(memReq), .memWe(memWe), .memIsPm(memIsPm), .memAddr(memAddr),
    .memWdata(memWdata), .memRdata(memRdata), .ovlSel(ovlSel)
  );

  function automatic logic [23:0] memModel(input logic [13:0] a, input logic pm);
    return pm ? {a[13:6] ^ 8'hC3, 2'b01, a} : {8'h00, 2'b10, a};
  endfunction

  // registered memory model and traffic log
  always @(posedge clk) begin
    if (memReq) begin
      reqCount <= reqCount + 1;
      if (memWe) begin
        wrCount    <= wrCount + 1;
        lastWrAddr <= memAddr;
        lastWrData <= memWdata;
        lastWrPm   <= memIsPm;
      end else begin
        memRdata <= memModel(memAddr, memIsPm);
      end
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic latchWord(input logic [15:0] w);
    @(negedge clk);
    hostBusIn = w; hostSelN = 1'b0; hostLatch = 1'b1;
    repeat (4) @(negedge clk);
    hostLatch = 1'b0;
    repeat (4) @(negedge clk);
    hostSelN = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic waitAck(input string tag);
    int n = 0;
    while (hostAck && n < 50) begin @(negedge clk); n++; end
    check({tag, " ack falls"}, 32'(hostAck), 32'd0);
    n = 0;
    while (!hostAck && n < 50) begin @(negedge clk); n++; end
    check({tag, " ack rises"}, 32'(hostAck), 32'd1);
  endtask

  task automatic access(input logic isWrite, input logic [15:0] w, input string tag,
                        output logic [15:0] rd);
    @(negedge clk);
    hostBusIn = w; hostSelN = 1'b0;
    if (isWrite) hostWrN = 1'b0; else hostRdN = 1'b0;
    waitAck(tag);
    rd = hostBusOut;
    hostRdN = 1'b1; hostWrN = 1'b1; hostSelN = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  // {op[1:0], bus[15:0], expected[23:0], expAddr[13:0], expPm, reqDelta}
  // op: 0 latch, 1 read, 2 write with memory cycle, 3 write without
  localparam int NVEC = 13;
  localparam logic [57:0] VEC [NVEC] = '{
    {2'd0, 16'h0010, 24'h000000, 14'h0000, 1'b0, 1'b0},
    {2'd1, 16'h0000, 24'h008010, 14'h0000, 1'b0, 1'b1},
    {2'd1, 16'h0000, 24'h008011, 14'h0000, 1'b0, 1'b1},
    {2'd2, 16'h1234, 24'h001234, 14'h0012, 1'b0, 1'b1},
    {2'd1, 16'h0000, 24'h008013, 14'h0000, 1'b0, 1'b1},
    {2'd0, 16'h4105, 24'h000000, 14'h0000, 1'b0, 1'b0},
    {2'd1, 16'h0000, 24'h00C741, 14'h0000, 1'b0, 1'b1},
    {2'd1, 16'h0000, 24'h000005, 14'h0000, 1'b0, 1'b0},
    {2'd1, 16'h0000, 24'h00C741, 14'h0000, 1'b0, 1'b1},
    {2'd1, 16'h0000, 24'h000006, 14'h0000, 1'b0, 1'b0},
    {2'd3, 16'hABCD, 24'h000000, 14'h0000, 1'b0, 1'b0},
    {2'd2, 16'h00EF, 24'hABCDEF, 14'h0107, 1'b1, 1'b1},
    {2'd0, 16'h8055, 24'h000000, 14'h0000, 1'b0, 1'b0}
  };

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin : stim
    logic [15:0] rd;
    int r0, w0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 ack", 32'(hostAck), 32'd1);
    check("R1 memReq", 32'(memReq), 32'd0);
    check("R1 ovlSel", 32'(ovlSel), 32'd0);
    check("R1 busOut", 32'(hostBusOut), 32'd0);
    access(1'b0, 16'h0, "R1 read at reset address", rd);
    check("R1 data memory word 0", 32'(rd), 32'h8000);

    for (int i = 0; i < NVEC; i++) begin
      logic [1:0]  op;
      logic [15:0] bus;
      logic [23:0] exp;
      logic [13:0] ea;
      logic        epm, rq;
      {op, bus, exp, ea, epm, rq} = VEC[i];
      r0 = reqCount; w0 = wrCount;
      case (op)
        2'd0: latchWord(bus);
        2'd1: begin
          access(1'b0, bus, "R5 R8 read", rd);
          check("R2 R5 R7 R8 read data", 32'(rd), 32'(exp[15:0]));
          check("R11 R8 memory cycles per read", 32'(reqCount - r0), 32'(rq));
        end
        2'd2: begin
          access(1'b1, bus, "R6 R9 write", rd);
          check("R6 R9 write data", 32'(lastWrData), 32'(exp));
          check("R2 R7 write address", 32'(lastWrAddr), 32'(ea));
          check("R2 write memory select", 32'(lastWrPm), 32'(epm));
          check("R11 one write cycle", 32'(wrCount - w0), 32'd1);
          check("R11 one request", 32'(reqCount - r0), 32'(rq));
        end
        default: begin
          access(1'b1, bus, "R9 first half", rd);
          check("R9 no cycle on first half", 32'(reqCount - r0), 32'd0);
        end
      endcase
    end

    // R3 overlay latched, address kept
    check("R3 overlay value", 32'(ovlSel), 32'h55);

    // R12 synchronizer delay, then finish the read at PM 0x108
    @(negedge clk);
    hostSelN = 1'b0; hostRdN = 1'b0;
    @(negedge clk);
    check("R12 ack after one edge", 32'(hostAck), 32'd1);
    @(negedge clk);
    check("R12 ack after two edges", 32'(hostAck), 32'd1);
    check("R12 no request yet", 32'(memReq), 32'd0);
    waitAck("R12");
    check("R3 address unchanged by overlay", 32'(hostBusOut), 32'hC741);
    hostSelN = 1'b1; hostRdN = 1'b1;
    repeat (4) @(negedge clk);

    // R4 reserved bits set: ignored
    latchWord(16'h8155);
    check("R4 overlay unchanged", 32'(ovlSel), 32'h55);
    r0 = reqCount;
    access(1'b0, 16'h0, "R4 read", rd);
    check("R4 address and phase kept", 32'(rd), 32'h0008);
    check("R4 no cycle on low half", 32'(reqCount - r0), 32'd0);

    // R10 boundary: last writable data word
    latchWord(16'h3FDF);
    access(1'b1, 16'h2468, "R10 boundary write", rd);
    check("R10 write below base", 32'(lastWrAddr), 32'h3FDF);
    check("R10 data below base", 32'(lastWrData), 32'h002468);

    // R10 protected write, then R7 wrap
    latchWord(16'h3FFF);
    r0 = reqCount; w0 = wrCount;
    access(1'b1, 16'h5555, "R10 protected write", rd);
    check("R10 no write cycle", 32'(wrCount - w0), 32'd0);
    check("R10 no request", 32'(reqCount - r0), 32'd0);
    access(1'b0, 16'h0, "R7 wrap read", rd);
    check("R7 R10 address wrapped to 0", 32'(rd), 32'h8000);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule